// File: doc/BRIEF.md
# Differential Symbol Encoder for BPSK and QPSK Transmit

This block turns a serial transmit bit stream into modulation symbols. Each bit is captured on a bit strobe. In QPSK mode, two successive bits make one symbol: the first bit is the in-phase (I) bit and the second is the quadrature (Q) bit. In BPSK mode, every bit is a symbol of its own and is carried on I. On each symbol strobe the most recently assembled symbol is either passed through as it is or differentially encoded, and it is then presented on registered outputs together with a one-cycle valid flag.

The block also follows a burst-enable input and produces two outputs from it. The first is a one-cycle reload pulse for the carrier oscillator, issued when a burst starts. The second is a burst-active flag that covers the whole time downstream output is busy. That flag rises only after a short count of symbol periods and falls only after a longer count. The counts are taken from the symbol strobe.

Top module: `sym_diff_enc`

## Requirements
- R1: On a QPSK symbol strobe, sym_i_o takes the first bit and sym_q_o takes the second bit of the last completed pair. Both outputs change in the cycle after sym_stb_i. sym_vld_o is high for exactly that one cycle.
- R2: When bpsk_i=1, every bit strobe completes a symbol on I, and sym_q_o is 0 on every symbol produced in this mode.
- R3: When diff_en_i=0 at a symbol strobe, the raw symbol is output unchanged.
- R4: For BPSK with differential encoding on, the output I bit equals the input bit XOR the previous output I bit.
- R5: For QPSK with differential encoding on, the symbol codes {I,Q} are ordered on the cycle 00,01,11,10. The output code is the previous output code advanced along that cycle by 0 positions for input 00, by 1 for input 01, by 2 for input 11 and by 3 for input 10.
- R6: At the first symbol strobe with diff_en_i=1 after a strobe with diff_en_i=0 (or after reset), the symbol is encoded against a reference of 0 or 00 instead of the previous output.
- R7: A rising edge of burst_en_i restarts pair alignment, so the next bit strobe delivers I even when a lone bit was pending.
- R8: reload_o pulses high for one cycle, in the cycle after burst_en_i goes from 0 to 1.
- R9: burst_act_o rises in the cycle after the ON_DLY-th (default 2) symbol strobe seen while burst_en_i is high and burst_act_o is low.
- R10: burst_act_o falls in the cycle after the OFF_DLY-th (default 11) symbol strobe seen while burst_en_i is low and burst_act_o is high. Any change of burst_en_i back to the current state of burst_act_o clears that count: a burst restarted during the tail keeps the flag high, and a burst that ends before its flag has risen leaves the flag low.
- R11: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | Qualifies bit_i for one cycle |
| bit_i | input | 1 | Serial transmit bit |
| sym_stb_i | input | 1 | Symbol period tick |
| bpsk_i | input | 1 | 1 = BPSK, 0 = QPSK |
| diff_en_i | input | 1 | Differential encoding enable |
| burst_en_i | input | 1 | Burst enable |
| sym_i_o | output | 1 | Encoded I bit |
| sym_q_o | output | 1 | Encoded Q bit |
| sym_vld_o | output | 1 | New symbol on sym_i_o/sym_q_o |
| reload_o | output | 1 | Oscillator reload pulse |
| burst_act_o | output | 1 | Burst output activity window |

## Verification
The bench builds the block with its default counts, ON_DLY=2 and OFF_DLY=11. With these values it can walk through the full start delay, the full tail, a burst restarted in the middle of the tail and a burst cancelled before its flag rises, all within a few dozen symbol strobes. A vector table takes the encoder through every one of the four DQPSK rotation steps, DBPSK chains, reference restarts in both modes, and mode changes that reuse the previous output as the reference.

// File: rtl/sym_enc_pkg.sv
package sym_enc_pkg;
  typedef struct packed {
    logic i;
    logic q;
  } sym_t;

  // position on the 00,01,11,10 cycle
  function automatic logic [1:0] gray_to_idx(sym_t s);
    return {s.i, s.i ^ s.q};
  endfunction

  function automatic sym_t idx_to_gray(logic [1:0] idx);
    sym_t s;
    s.i = idx[1];
    s.q = idx[1] ^ idx[0];
    return s;
  endfunction
endpackage

// File: rtl/bit_pairer.sv
module bit_pairer
  import sym_enc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic bit_i,
  input  logic bpsk_i,
  input  logic realign_i,
  output sym_t sym_o
);
  logic phase_q;
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
      sym_o   <= '0;
    end else if (bit_stb_i) begin
      if (bpsk_i) begin
        sym_o   <= '{i: bit_i, q: 1'b0};
        phase_q <= 1'b0;
      end else if (phase_q && !realign_i) begin
        sym_o   <= '{i: first_q, q: bit_i};
        phase_q <= 1'b0;
      end else begin
        first_q <= bit_i;
        phase_q <= 1'b1;
      end
    end else if (realign_i) begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/diff_coder.sv
module diff_coder
  import sym_enc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic bpsk_i,
  input  logic diff_en_i,
  input  sym_t raw_i,
  output sym_t sym_o,
  output logic vld_o
);
  logic diff_d_q;
  sym_t ref_s, enc_s, out_s;

  always_comb begin
    ref_s = (diff_en_i && !diff_d_q) ? '0 : sym_o;
    if (bpsk_i) begin
      enc_s.i = raw_i.i ^ ref_s.i;
      enc_s.q = 1'b0;
    end else begin
      enc_s = idx_to_gray(gray_to_idx(raw_i) + gray_to_idx(ref_s));
    end
    out_s = diff_en_i ? enc_s : raw_i;
    if (bpsk_i) out_s.q = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o    <= '0;
      vld_o    <= 1'b0;
      diff_d_q <= 1'b0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) begin
        sym_o    <= out_s;
        diff_d_q <= diff_en_i;
      end
    end
  end
endmodule

// File: rtl/burst_tracker.sv
module burst_tracker #(
  parameter int unsigned ON_DLY  = 2,
  parameter int unsigned OFF_DLY = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic burst_en_i,
  input  logic sym_stb_i,
  output logic rise_o,
  output logic reload_o,
  output logic act_o
);
  localparam int unsigned MaxDly = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int unsigned CntW   = (MaxDly > 1) ? $clog2(MaxDly) : 1;
  localparam logic [CntW-1:0] OnLast  = CntW'(ON_DLY - 1);
  localparam logic [CntW-1:0] OffLast = CntW'(OFF_DLY - 1);

  logic            en_q;
  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] lim_s;

  assign rise_o = burst_en_i && !en_q;
  assign lim_s  = burst_en_i ? OnLast : OffLast;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      reload_o <= 1'b0;
      act_o    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      en_q     <= burst_en_i;
      reload_o <= rise_o;
      if (burst_en_i == act_o) begin
        cnt_q <= '0;
      end else if (sym_stb_i) begin
        if (cnt_q == lim_s) begin
          act_o <= ~act_o;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sym_diff_enc.sv
module sym_diff_enc
  import sym_enc_pkg::*;
#(
  parameter int unsigned ON_DLY  = 2,
  parameter int unsigned OFF_DLY = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic bit_i,
  input  logic sym_stb_i,
  input  logic bpsk_i,
  input  logic diff_en_i,
  input  logic burst_en_i,
  output logic sym_i_o,
  output logic sym_q_o,
  output logic sym_vld_o,
  output logic reload_o,
  output logic burst_act_o
);
  sym_t raw_s, enc_s;
  logic rise_s;

  burst_tracker #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_burst (
    .clk_i, .rst_ni, .burst_en_i, .sym_stb_i,
    .rise_o(rise_s), .reload_o, .act_o(burst_act_o)
  );

  bit_pairer u_pair (
    .clk_i, .rst_ni, .bit_stb_i, .bit_i, .bpsk_i,
    .realign_i(rise_s), .sym_o(raw_s)
  );

  diff_coder u_code (
    .clk_i, .rst_ni, .stb_i(sym_stb_i), .bpsk_i, .diff_en_i,
    .raw_i(raw_s), .sym_o(enc_s), .vld_o(sym_vld_o)
  );

  assign sym_i_o = enc_s.i;
  assign sym_q_o = enc_s.q;
endmodule

// File: rtl/sym_diff_enc_chk.sv
module sym_diff_enc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sym_stb_i,
  input logic bpsk_i,
  input logic burst_en_i,
  input logic sym_q_o,
  input logic sym_vld_o,
  input logic reload_o,
  input logic burst_act_o
);
  AST_VLD_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_stb_i |=> sym_vld_o);  // R1
  AST_NO_VLD_WITHOUT_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> !sym_vld_o);  // R1
  AST_BPSK_Q_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_stb_i && bpsk_i) |=> !sym_q_o);  // R2
  AST_RELOAD_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_en_i) |=> reload_o);  // R8
  AST_RELOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o);  // R8
  AST_ACT_RISE_WHILE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_act_o) |-> $past(burst_en_i) && $past(sym_stb_i));  // R9
  AST_ACT_FALL_WHILE_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_act_o) |-> !$past(burst_en_i) && $past(sym_stb_i));  // R10
endmodule

bind sym_diff_enc sym_diff_enc_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sym_stb_i(sym_stb_i), .bpsk_i(bpsk_i),
  .burst_en_i(burst_en_i), .sym_q_o(sym_q_o), .sym_vld_o(sym_vld_o),
  .reload_o(reload_o), .burst_act_o(burst_act_o)
);

// File: tb/sym_diff_enc_tb.sv
module sym_diff_enc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 0, bit_v = 0, sym_stb = 0, bpsk = 0, diff_en = 0, burst_en = 0;
  logic sym_i, sym_q, sym_vld, reload, act;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sym_diff_enc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .bit_i(bit_v),
    .sym_stb_i(sym_stb), .bpsk_i(bpsk), .diff_en_i(diff_en), .burst_en_i(burst_en),
    .sym_i_o(sym_i), .sym_q_o(sym_q), .sym_vld_o(sym_vld),
    .reload_o(reload), .burst_act_o(act)
  );

  // {bpsk, diff, bit0, bit1, exp_i, exp_q}
  localparam logic [5:0] VEC [16] = '{
    6'b001010, 6'b000101, 6'b010101, 6'b011110,
    6'b011011, 6'b010011, 6'b010110, 6'b111000,
    6'b111010, 6'b111000, 6'b110000, 6'b101010,
    6'b111010, 6'b110010, 6'b001111, 6'b011010
  };

  task automatic chk(input string req, input logic [3:0] act_v, input logic [3:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act_v, exp_v);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb = 1; bit_v = b;
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic sym_pulse();
    @(negedge clk); sym_stb = 1;
    @(negedge clk); sym_stb = 0;
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset", {sym_i, sym_q, sym_vld, reload | act}, 4'b0000);
    rst_n = 1;

    for (int k = 0; k < 16; k++) begin
      @(negedge clk); bpsk = VEC[k][5]; diff_en = VEC[k][4];
      send_bit(VEC[k][3]);
      if (!VEC[k][5]) send_bit(VEC[k][2]);
      sym_pulse();
      chk($sformatf("R1 R2 R3 R4 R5 R6 vec%0d", k), {sym_vld, sym_i, sym_q, 1'b0},
          {1'b1, VEC[k][1], VEC[k][0], 1'b0});
    end
    @(negedge clk);
    chk("R1 vld single", {3'b0, sym_vld}, 4'b0000);

    // R7: stray bit, then burst rise realigns
    bpsk = 0; diff_en = 0;
    send_bit(1);
    @(negedge clk); burst_en = 1;
    @(negedge clk);
    chk("R8 reload", {3'b0, reload}, 4'b0001);
    @(negedge clk);
    chk("R8 reload one cycle", {3'b0, reload}, 4'b0000);
    send_bit(0); send_bit(1);
    sym_pulse();
    chk("R7 realign", {2'b0, sym_i, sym_q}, 4'b0001);
    chk("R9 one strobe", {3'b0, act}, 4'b0000);
    sym_pulse();
    chk("R9 rise", {3'b0, act}, 4'b0001);

    @(negedge clk); burst_en = 0;
    for (int k = 0; k < 10; k++) sym_pulse();
    chk("R10 tail held", {3'b0, act}, 4'b0001);
    sym_pulse();
    chk("R10 fall", {3'b0, act}, 4'b0000);

    @(negedge clk); burst_en = 1;
    sym_pulse(); sym_pulse();
    @(negedge clk); burst_en = 0;
    for (int k = 0; k < 5; k++) sym_pulse();
    @(negedge clk); burst_en = 1;
    for (int k = 0; k < 12; k++) sym_pulse();
    chk("R10 restart in tail", {3'b0, act}, 4'b0001);

    @(negedge clk); burst_en = 0;
    for (int k = 0; k < 11; k++) sym_pulse();
    chk("R10 fall again", {3'b0, act}, 4'b0000);
    @(negedge clk); burst_en = 1;
    sym_pulse();
    @(negedge clk); burst_en = 0;
    sym_pulse(); sym_pulse(); sym_pulse();
    chk("R10 cancelled", {3'b0, act}, 4'b0000);
    @(negedge clk); burst_en = 1;
    sym_pulse();
    chk("R10 count cleared", {3'b0, act}, 4'b0000);
    sym_pulse();
    chk("R9 rise after cancel", {3'b0, act}, 4'b0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule